// File: doc/BRIEF.md
# Partitioned Lane Shifter

This block shifts a 16-bit word as a set of independent lanes. A small break mask chosen at run time splits the word into one 16-bit lane, two 8-bit lanes, four 4-bit lanes, or a mix of 4-bit and 8-bit lanes. Each lane is shifted logically left or right by its own amount. Bits that leave a lane are dropped, and zeros enter from the opposite edge. No bit ever moves into a neighbouring lane.

The shift amount comes from operand B in one of two ways. In per-lane mode each lane reads the bits of B that start at that lane's lowest bit position. In shared mode every lane reads the lowest bits of B. In both modes the amount is cut to the low log2(lane width) bits of the lane that uses it, so every amount wraps modulo that lane's width.

The shift network is combinational. The result is captured in one output register, so a result appears one clock after its operands. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `lane_shifter`

## Requirements
- R1: `brk_i` holds three break flags. Bit 0 places a lane edge between result bits 3 and 4, bit 1 between bits 7 and 8, and bit 2 between bits 11 and 12. The encodings give these lanes: 000 gives one 16-bit lane, 010 gives two 8-bit lanes, 111 gives four 4-bit lanes, 011 gives lanes 4,4,8 from the low end, and 110 gives lanes 8,4,4.
- R2: With `dir_i`=0 (left), each lane's bits move toward the lane's MSB by the amount. Bits pushed past the lane's top are lost, and zeros fill the low end of the lane.
- R3: With `dir_i`=1 (right), each lane's bits move toward the lane's LSB by the amount. Bits pushed past the lane's bottom are lost, and zeros fill the top of the lane.
- R4: With `mode_i`=0 (per lane), a lane whose lowest bit is L and whose width is w shifts by B[L+log2(w)-1 : L].
- R5: With `mode_i`=1 (shared), every lane of width w shifts by B[log2(w)-1 : 0].
- R6: When the lane widths are mixed, each lane cuts its amount using its own width. One shared B can therefore give different amounts to the 4-bit lanes and the 8-bit lane.
- R7: Flag bits 0 and 2 of `brk_i` are ignored while bit 1 is clear. Masks 001, 100 and 101 give the same result as 000.
- R8: `res_o` shows the result for the operands present at the previous rising clock edge. A new operation can be accepted on every cycle.
- R9: While reset is active, and until its synchronised release, `res_o` is 0.
- R10: An amount that works out to 0 passes the lane through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | Data word to be shifted |
| b_i | input | 16 | Shift amount source |
| brk_i | input | 3 | Lane break flags (R1) |
| dir_i | input | 1 | 0 left, 1 right |
| mode_i | input | 1 | 0 per-lane amount, 1 shared amount |
| res_o | output | 16 | Registered shifted word |

## Verification
In a single cycle, a lane can both wrap its amount to its width and drop bits at its edge. This happens in shared mode when B is larger than 3 and the break mask holds 4-bit lanes next to an 8-bit lane. The bench drives those mixes back to back with both directions. Each registered result is compared with an independent lane-by-lane model held in a scoreboard queue.

// File: rtl/lane_shifter_pkg.sv
package lane_shifter_pkg;

  typedef enum logic {SHIFT_LEFT = 1'b0, SHIFT_RIGHT = 1'b1} shift_dir_e;
  typedef enum logic {AMT_PER_LANE = 1'b0, AMT_SHARED = 1'b1} amt_mode_e;

  // Enclosing edge of edge k at stride s in the binary break tree:
  // the neighbour at distance s that is an odd multiple of 2*s.
  function automatic int edge_parent(int k, int s);
    if ((((k - s) / (2 * s)) % 2) == 1) return k - s;
    return k + s;
  endfunction

endpackage

// File: rtl/lane_map.sv
module lane_map #(
  parameter int SEG_N = 4,
  localparam int IDX_W = $clog2(SEG_N)
) (
  input  logic [SEG_N-2:0]            brk_i,
  output logic [SEG_N-1:0][IDX_W-1:0] lo_seg_o,
  output logic [SEG_N-1:0][IDX_W-1:0] hi_seg_o
);
  // edge_q[k]=1: a lane starts at segment k. Segment 0 always starts one.
  logic [SEG_N-1:0] edge_q;

  always_comb begin
    edge_q    = '0;
    edge_q[0] = 1'b1;
    for (int s = SEG_N / 2; s >= 1; s = s / 2) begin
      for (int k = s; k < SEG_N; k = k + 2 * s) begin
        if (s == SEG_N / 2) edge_q[k] = brk_i[k-1];
        else edge_q[k] = brk_i[k-1] & edge_q[lane_shifter_pkg::edge_parent(k, s)];
      end
    end
  end

  always_comb begin
    for (int n = 0; n < SEG_N; n++) begin
      lo_seg_o[n] = '0;
      for (int m = 0; m <= n; m++)
        if (edge_q[m]) lo_seg_o[n] = IDX_W'(m);
      hi_seg_o[n] = IDX_W'(SEG_N - 1);
      for (int m = SEG_N - 1; m > n; m--)
        if (edge_q[m]) hi_seg_o[n] = IDX_W'(m - 1);
    end
  end
endmodule

// File: rtl/lane_amount.sv
module lane_amount #(
  parameter int SEG_W = 4,
  parameter int SEG_N = 4,
  localparam int W     = SEG_W * SEG_N,
  localparam int AMT_W = $clog2(W),
  localparam int IDX_W = $clog2(SEG_N),
  localparam int PAD_W = W + AMT_W,
  localparam int PIX_W = $clog2(PAD_W)
) (
  input  logic [W-1:0]                b_i,
  input  logic                        mode_i,
  input  logic [SEG_N-1:0][IDX_W-1:0] lo_seg_i,
  input  logic [SEG_N-1:0][IDX_W-1:0] hi_seg_i,
  output logic [SEG_N-1:0][AMT_W-1:0] amt_o
);
  import lane_shifter_pkg::*;

  logic [PAD_W-1:0] b_pad;
  assign b_pad = {{AMT_W{1'b0}}, b_i};

  for (genvar n = 0; n < SEG_N; n++) begin : g_seg
    logic [AMT_W-1:0] wrap_m;
    logic [AMT_W-1:0] field;
    logic [PIX_W-1:0] base;

    always_comb begin
      wrap_m = AMT_W'((int'(hi_seg_i[n]) - int'(lo_seg_i[n]) + 1) * SEG_W - 1);
      base   = PIX_W'(int'(lo_seg_i[n]) * SEG_W);
      field  = b_pad[base +: AMT_W];
      if (amt_mode_e'(mode_i) == AMT_SHARED) amt_o[n] = b_i[AMT_W-1:0] & wrap_m;
      else amt_o[n] = field & wrap_m;
    end
  end
endmodule

// File: rtl/lane_shift_core.sv
module lane_shift_core #(
  parameter int SEG_W = 4,
  parameter int SEG_N = 4,
  localparam int W     = SEG_W * SEG_N,
  localparam int AMT_W = $clog2(W),
  localparam int IDX_W = $clog2(SEG_N),
  localparam int BIT_W = $clog2(W)
) (
  input  logic [W-1:0]                a_i,
  input  logic                        dir_i,
  input  logic [SEG_N-1:0][IDX_W-1:0] lo_seg_i,
  input  logic [SEG_N-1:0][IDX_W-1:0] hi_seg_i,
  input  logic [SEG_N-1:0][AMT_W-1:0] amt_i,
  output logic [W-1:0]                y_o
);
  import lane_shifter_pkg::*;

  for (genvar j = 0; j < W; j++) begin : g_bit
    localparam int SEG = j / SEG_W;
    logic bit_v;
    int   lo_b, hi_b, sh;

    always_comb begin
      lo_b  = int'(lo_seg_i[SEG]) * SEG_W;
      hi_b  = (int'(hi_seg_i[SEG]) + 1) * SEG_W - 1;
      sh    = int'(amt_i[SEG]);
      bit_v = 1'b0;
      if (shift_dir_e'(dir_i) == SHIFT_LEFT) begin
        if (j - sh >= lo_b) bit_v = a_i[BIT_W'(j - sh)];
      end else begin
        if (j + sh <= hi_b) bit_v = a_i[BIT_W'(j + sh)];
      end
    end

    assign y_o[j] = bit_v;
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int SEG_W = 4,
  parameter int SEG_N = 4,
  localparam int W     = SEG_W * SEG_N,
  localparam int AMT_W = $clog2(W),
  localparam int IDX_W = $clog2(SEG_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [SEG_N-2:0] brk_i,
  input  logic             dir_i,
  input  logic             mode_i,
  output logic [W-1:0]     res_o
);
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic [SEG_N-1:0][IDX_W-1:0] lo_seg, hi_seg;
  logic [SEG_N-1:0][AMT_W-1:0] amt;
  logic [W-1:0]                res_d, res_q;

  lane_map #(.SEG_N(SEG_N)) u_map (
    .brk_i   (brk_i),
    .lo_seg_o(lo_seg),
    .hi_seg_o(hi_seg)
  );

  lane_amount #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_amt (
    .b_i     (b_i),
    .mode_i  (mode_i),
    .lo_seg_i(lo_seg),
    .hi_seg_i(hi_seg),
    .amt_o   (amt)
  );

  lane_shift_core #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_core (
    .a_i     (a_i),
    .dir_i   (dir_i),
    .lo_seg_i(lo_seg),
    .hi_seg_i(hi_seg),
    .amt_i   (amt),
    .y_o     (res_d)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) res_q <= '0;
    else         res_q <= res_d;
  end
  assign res_o = res_q;

  // A zero word stays zero whatever the lanes and amounts
  assert_zero_src_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (a_i == '0) |=> (res_o == '0));

  // A shared amount of zero passes the word through unchanged
  assert_zero_amt_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i && b_i[AMT_W-1:0] == '0) |=> (res_o == $past(a_i)));

  // An odd shared amount on a left shift fills bit 0 with zero
  assert_left_fill_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (!dir_i && mode_i && b_i[0]) |=> !res_o[0]);

  // An odd shared amount on a right shift fills the top bit with zero
  assert_right_fill_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (dir_i && mode_i && b_i[0]) |=> !res_o[W-1]);

endmodule

// File: tb/lane_shifter_bench.sv
module lane_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] a, b, res;
  logic [2:0]  brk;
  logic        dir, mode;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  lane_shifter u_lane_shifter (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .brk_i(brk),
    .dir_i(dir), .mode_i(mode), .res_o(res)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  // Independent lane model built from R1..R7
  function automatic logic [15:0] model(logic [15:0] av, logic [15:0] bv,
                                        logic [2:0] bk, logic dv, logic mv);
    int lo_l[4];
    int w_l[4];
    int cnt = 0;
    logic [15:0] r = '0;
    if (!bk[1]) begin lo_l[0] = 0; w_l[0] = 16; cnt = 1; end
    else begin
      if (bk[0]) begin lo_l[0] = 0; w_l[0] = 4; lo_l[1] = 4; w_l[1] = 4; cnt = 2; end
      else begin lo_l[0] = 0; w_l[0] = 8; cnt = 1; end
      if (bk[2]) begin lo_l[cnt] = 8; w_l[cnt] = 4; lo_l[cnt+1] = 12; w_l[cnt+1] = 4; cnt += 2; end
      else begin lo_l[cnt] = 8; w_l[cnt] = 8; cnt += 1; end
    end
    for (int i = 0; i < cnt; i++) begin
      int          amt;
      logic [31:0] fld, msk;
      msk = (32'd1 << w_l[i]) - 1;
      amt = mv ? int'(bv) & (w_l[i] - 1) : (int'(bv) >> lo_l[i]) & (w_l[i] - 1);
      fld = (32'(av) >> lo_l[i]) & msk;
      fld = dv ? (fld >> amt) : ((fld << amt) & msk);
      r   = r | 16'(fld << lo_l[i]);
    end
    return r;
  endfunction

  task automatic drive(logic [15:0] av, logic [15:0] bv, logic [2:0] bk,
                       logic dv, logic mv, logic [15:0] exp, string tag);
    item_t it;
    @(negedge clk);
    a = av; b = bv; brk = bk; dir = dv; mode = mv;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drive_m(logic [15:0] av, logic [15:0] bv, logic [2:0] bk,
                         logic dv, logic mv, string tag);
    drive(av, bv, bk, dv, mv, model(av, bv, bk, dv, mv), tag);
  endtask

  // Monitor: one result per rising edge, sampled 1 ns later (R8)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (res !== it.exp) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, res, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a = 16'hFFFF; b = 16'h0001; brk = 3'b000; dir = 1'b0; mode = 1'b1;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (res !== 16'h0) begin
        errors++;
        $display("FAIL R9 actual %h expected 0000", res);
      end
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res !== 16'h0) begin
      errors++;
      $display("FAIL R9 sync release actual %h expected 0000", res);
    end
    repeat (3) @(negedge clk);

    // Hand-computed values
    drive(16'h1234, 16'h0004, 3'b000, 1'b0, 1'b1, 16'h2340, "R2 16-bit left by 4");
    drive(16'h1234, 16'h0004, 3'b000, 1'b1, 1'b1, 16'h0123, "R3 16-bit right by 4");
    drive(16'hFFFF, 16'h0001, 3'b111, 1'b1, 1'b1, 16'h7777, "R1 R3 four 4-bit right by 1");
    drive(16'h8181, 16'h0104, 3'b010, 1'b0, 1'b0, 16'h0210, "R1 R4 two 8-bit per-lane left");
    drive(16'hFFFF, 16'h0007, 3'b011, 1'b0, 1'b1, 16'h8088, "R6 mixed 4,4,8 shared left by 7");
    drive(16'hFFFF, 16'h0007, 3'b110, 1'b1, 1'b1, 16'h1101, "R6 mixed 8,4,4 shared right by 7");
    drive(16'hABCD, 16'h0010, 3'b000, 1'b0, 1'b1, 16'hABCD, "R10 shared amount wraps to 0");
    drive(16'hBEEF, 16'h4848, 3'b111, 1'b1, 1'b0, 16'hBEEF, "R10 R4 per-lane amounts wrap to 0");

    // R7: flags 0 and 2 without flag 1
    foreach (sb_q[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [2:0] bk;
      bk = (k == 0) ? 3'b001 : (k == 1) ? 3'b100 : (k == 2) ? 3'b101 : 3'b000;
      drive(16'h1234, 16'h0004, bk, 1'b0, 1'b1, 16'h2340, "R7 stray flags ignored");
    end

    // Mixed widths back to back, shared amounts above 3 (R6, R8)
    for (int i = 0; i < 64; i++) begin
      logic [2:0] bk;
      bk = (i % 2 == 0) ? 3'b011 : 3'b110;
      drive_m(16'($urandom), 16'(4 + (i % 12)), bk, 1'(i / 2), 1'b1, "R6 R8 mixed burst");
    end

    // Random per-lane (R4) and shared (R5) runs over all break masks, both directions
    for (int i = 0; i < 400; i++)
      drive_m(16'($urandom), 16'($urandom), 3'($urandom), 1'($urandom), 1'b0, "R4 per-lane random");
    for (int i = 0; i < 400; i++)
      drive_m(16'($urandom), 16'($urandom), 3'($urandom), 1'($urandom), 1'b1, "R5 shared random");
    for (int i = 0; i < 50; i++)
      drive_m(16'($urandom), 16'($urandom), 3'b010, 1'b0, 1'($urandom), "R1 R2 two-lane left");
    for (int i = 0; i < 50; i++)
      drive_m(16'($urandom), 16'($urandom), 3'b111, 1'b1, 1'($urandom), "R1 R3 four-lane right");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule